// File: doc/BRIEF.md
# Logarithmic-Domain Multiply/Divide Unit

This block multiplies or divides two numbers held in a sign/logarithm format and returns the result in the same format. Each word carries a two-bit class tag, a sign bit and a base-2 logarithm of the magnitude. The logarithm is a two's-complement fixed-point value with `INT_W` integer bits and `FRAC_W` fraction bits, so negative values stand for magnitudes below one. In this format a product becomes a fixed-point addition of the logarithms and a quotient becomes a subtraction. The result is exact whenever it fits in the field.

The class tag encodes zero, infinity and NaN, none of which the logarithm can express. The unit resolves these cases with IEEE-like rules. A result whose logarithm leaves the representable range saturates to infinity when it is too large and to zero when it is too small. The operands are captured in input registers, combined in one cycle of logic and presented from an output register.

Top module: `lns_muldiv`

## Requirements
- R1: A word is `{class[1:0], sign, log[INT_W+FRAC_W-1:0]}` with class at the two top bits (00 zero, 01 normal, 10 infinity, 11 NaN), the sign just below them, and `log` a two's-complement value scaled by 2^-FRAC_W; `op_div` = 0 selects multiply and 1 selects divide.
- R2: Operands and `op_div` present before clock edge N produce `result` after edge N+1, and not after edge N; while `rst_n` is low, `result` is all zeros (a zero word).
- R3: Multiplying two normal operands gives a normal result whose log is exactly log_a + log_b when that sum lies in the representable range.
- R4: Dividing two normal operands gives a normal result whose log is exactly log_a − log_b when that difference lies in the representable range.
- R5: The result sign is the XOR of the two operand signs, in every case including exceptional results.
- R6: A sum or difference above the largest representable log gives infinity.
- R7: A sum or difference below the most negative representable log gives zero.
- R8: If either operand is NaN, the result is NaN, in both modes.
- R9: In multiply mode, zero times infinity (either order) is NaN; otherwise any infinity gives infinity, and otherwise any zero gives zero.
- R10: In divide mode, infinity/infinity and zero/zero are NaN; any other value over zero is infinity; zero over anything else is zero; normal over infinity is zero; infinity over normal is infinity.
- R11: Whenever the result class is not normal, the result log field is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| opnd_a | input | INT_W+FRAC_W+3 | First operand (multiplicand or dividend) |
| opnd_b | input | INT_W+FRAC_W+3 | Second operand (multiplier or divisor) |
| result | output | INT_W+FRAC_W+3 | Registered product or quotient |

## Verification
The bench builds the unit with `INT_W` = 3 and `FRAC_W` = 2. The log field then spans only −16 to +15 in units of a quarter. With a field that small, random normal operands overflow and underflow often. The exact boundary sums (+15 and −16) and the one-past values are also easy to hit on purpose. Random class tags are weighted toward normal, so the random traffic also covers every zero/infinity/NaN pairing in both modes.

// File: rtl/lns_pkg.sv
package lns_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NORM = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } lns_cls_e;

    // Outcome chosen by exception resolution before range checking
    typedef enum logic [1:0] {
        PICK_ARITH = 2'b00,
        PICK_ZERO  = 2'b01,
        PICK_INF   = 2'b10,
        PICK_NAN   = 2'b11
    } lns_pick_e;

endpackage

// File: rtl/lns_exc_resolve.sv
module lns_exc_resolve
    import lns_pkg::*;
(
    input  lns_cls_e  cls_a,
    input  lns_cls_e  cls_b,
    input  logic      is_div,
    output lns_pick_e pick
);

    always_comb begin
        pick = PICK_ARITH;
        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            pick = PICK_NAN;                              // R8
        end else if (!is_div) begin
            unique case ({cls_a, cls_b})
                {CLS_ZERO, CLS_INF},
                {CLS_INF,  CLS_ZERO}: pick = PICK_NAN;    // R9
                {CLS_INF,  CLS_INF},
                {CLS_INF,  CLS_NORM},
                {CLS_NORM, CLS_INF}:  pick = PICK_INF;
                {CLS_ZERO, CLS_ZERO},
                {CLS_ZERO, CLS_NORM},
                {CLS_NORM, CLS_ZERO}: pick = PICK_ZERO;
                default:              pick = PICK_ARITH;
            endcase
        end else begin
            unique case ({cls_a, cls_b})
                {CLS_INF,  CLS_INF},
                {CLS_ZERO, CLS_ZERO}: pick = PICK_NAN;    // R10
                {CLS_NORM, CLS_ZERO},
                {CLS_INF,  CLS_ZERO},
                {CLS_INF,  CLS_NORM}: pick = PICK_INF;
                {CLS_ZERO, CLS_NORM},
                {CLS_ZERO, CLS_INF},
                {CLS_NORM, CLS_INF}:  pick = PICK_ZERO;
                default:              pick = PICK_ARITH;
            endcase
        end
    end

endmodule

// File: rtl/lns_log_arith.sv
module lns_log_arith #(
    parameter int LOG_W = 31
) (
    input  logic [LOG_W-1:0] log_a,
    input  logic [LOG_W-1:0] log_b,
    input  logic             is_div,
    output logic [LOG_W-1:0] log_r,
    output logic             too_big,
    output logic             too_small
);

    localparam int EXT_W = LOG_W + 1;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] wide;

    always_comb begin
        ext_a = {log_a[LOG_W-1], log_a};
        ext_b = {log_b[LOG_W-1], log_b};
        wide  = is_div ? (ext_a - ext_b) : (ext_a + ext_b);
        // The top two bits disagree exactly when the value leaves LOG_W bits
        too_big   = ~wide[EXT_W-1] &  wide[EXT_W-2];
        too_small =  wide[EXT_W-1] & ~wide[EXT_W-2];
        log_r     = wide[LOG_W-1:0];
    end

endmodule

// File: rtl/lns_muldiv.sv
module lns_muldiv
    import lns_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_div,
    input  logic [INT_W+FRAC_W+2:0]   opnd_a,
    input  logic [INT_W+FRAC_W+2:0]   opnd_b,
    output logic [INT_W+FRAC_W+2:0]   result
);

    localparam int LOG_W  = INT_W + FRAC_W;
    localparam int WORD_W = LOG_W + 3;
    localparam int SGN_B  = LOG_W;

    logic [WORD_W-1:0] a_q;
    logic [WORD_W-1:0] b_q;
    logic              div_q;
    logic [WORD_W-1:0] res_q;

    lns_cls_e          cls_a;
    lns_cls_e          cls_b;
    lns_pick_e         pick;
    logic [LOG_W-1:0]  log_sum;
    logic              too_big;
    logic              too_small;
    logic [WORD_W-1:0] res_d;

    // Input register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            div_q <= 1'b0;
        end else begin
            a_q   <= opnd_a;
            b_q   <= opnd_b;
            div_q <= op_div;
        end
    end

    assign cls_a = lns_cls_e'(a_q[WORD_W-1:WORD_W-2]);
    assign cls_b = lns_cls_e'(b_q[WORD_W-1:WORD_W-2]);

    lns_exc_resolve u_exc (
        .cls_a  (cls_a),
        .cls_b  (cls_b),
        .is_div (div_q),
        .pick   (pick)
    );

    lns_log_arith #(.LOG_W(LOG_W)) u_arith (
        .log_a     (a_q[LOG_W-1:0]),
        .log_b     (b_q[LOG_W-1:0]),
        .is_div    (div_q),
        .log_r     (log_sum),
        .too_big   (too_big),
        .too_small (too_small)
    );

    // Result assembly
    always_comb begin
        logic sgn;
        sgn = a_q[SGN_B] ^ b_q[SGN_B];
        unique case (pick)
            PICK_NAN:  res_d = {CLS_NAN,  sgn, {LOG_W{1'b0}}};
            PICK_INF:  res_d = {CLS_INF,  sgn, {LOG_W{1'b0}}};
            PICK_ZERO: res_d = {CLS_ZERO, sgn, {LOG_W{1'b0}}};
            default: begin
                if (too_big)
                    res_d = {CLS_INF,  sgn, {LOG_W{1'b0}}};
                else if (too_small)
                    res_d = {CLS_ZERO, sgn, {LOG_W{1'b0}}};
                else
                    res_d = {CLS_NORM, sgn, log_sum};
            end
        endcase
    end

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result = res_q;

    // ---------------- assertions ----------------
    assert_log_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_q[WORD_W-1:WORD_W-2] != 2'b01) |-> (res_q[LOG_W-1:0] == '0));

    assert_sign_xor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (res_q[SGN_B] == ($past(a_q[SGN_B]) ^ $past(b_q[SGN_B]))));

    assert_nan_prop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q[WORD_W-1:WORD_W-2] == 2'b11 || b_q[WORD_W-1:WORD_W-2] == 2'b11)
        |=> (res_q[WORD_W-1:WORD_W-2] == 2'b11));

    assert_zero_inf_mul_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_q && ((a_q[WORD_W-1:WORD_W-2] == 2'b00 && b_q[WORD_W-1:WORD_W-2] == 2'b10) ||
                    (a_q[WORD_W-1:WORD_W-2] == 2'b10 && b_q[WORD_W-1:WORD_W-2] == 2'b00)))
        |=> (res_q[WORD_W-1:WORD_W-2] == 2'b11));

    assert_div_by_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q && b_q[WORD_W-1:WORD_W-2] == 2'b00 &&
         (a_q[WORD_W-1:WORD_W-2] == 2'b01 || a_q[WORD_W-1:WORD_W-2] == 2'b10))
        |=> (res_q[WORD_W-1:WORD_W-2] == 2'b10));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_ARITH && too_big) |=> (res_q[WORD_W-1:WORD_W-2] == 2'b10));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_ARITH && too_small) |=> (res_q[WORD_W-1:WORD_W-2] == 2'b00));

endmodule

// File: tb/lns_muldiv_tb_top.sv
module lns_muldiv_tb_top;

    localparam int INT_W  = 3;
    localparam int FRAC_W = 2;
    localparam int LOG_W  = INT_W + FRAC_W;
    localparam int WORD_W = LOG_W + 3;
    localparam int LMAX   = (1 << (LOG_W - 1)) - 1;
    localparam int LMIN   = -(1 << (LOG_W - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_div = 1'b0;
    logic [WORD_W-1:0] opnd_a = '0;
    logic [WORD_W-1:0] opnd_b = '0;
    logic [WORD_W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lns_muldiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_div (op_div),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    function automatic logic [WORD_W-1:0] mk(input logic [1:0] c, input logic s, input int lg);
        logic [LOG_W-1:0] l;
        l = LOG_W'(lg);
        return {c, s, l};
    endfunction

    // Reference model, written from the requirements (class codes per R1)
    function automatic logic [WORD_W-1:0] ref_word(input logic d, input logic [WORD_W-1:0] a,
                                                   input logic [WORD_W-1:0] b, output string req);
        logic [1:0] fa, fb;
        logic s;
        int la, lb, r;
        fa = a[WORD_W-1:WORD_W-2];
        fb = b[WORD_W-1:WORD_W-2];
        s  = a[LOG_W] ^ b[LOG_W];
        la = int'($signed(a[LOG_W-1:0]));
        lb = int'($signed(b[LOG_W-1:0]));
        if (fa == 2'b11 || fb == 2'b11) begin req = "R8"; return mk(2'b11, s, 0); end
        if (!d) begin
            req = "R9";
            if ((fa == 2'b00 && fb == 2'b10) || (fa == 2'b10 && fb == 2'b00)) return mk(2'b11, s, 0);
            if (fa == 2'b10 || fb == 2'b10) return mk(2'b10, s, 0);
            if (fa == 2'b00 || fb == 2'b00) return mk(2'b00, s, 0);
            req = "R3";
            r = la + lb;
        end else begin
            req = "R10";
            if ((fa == 2'b10 && fb == 2'b10) || (fa == 2'b00 && fb == 2'b00)) return mk(2'b11, s, 0);
            if (fb == 2'b00) return mk(2'b10, s, 0);
            if (fa == 2'b00) return mk(2'b00, s, 0);
            if (fb == 2'b10) return mk(2'b00, s, 0);
            if (fa == 2'b10) return mk(2'b10, s, 0);
            req = "R4";
            r = la - lb;
        end
        if (r > LMAX) begin req = "R6"; return mk(2'b10, s, 0); end
        if (r < LMIN) begin req = "R7"; return mk(2'b00, s, 0); end
        return mk(2'b01, s, r);
    endfunction

    task automatic check(input string req, input logic [WORD_W-1:0] got, input logic [WORD_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One operation: drive at a falling edge, result follows the second rising edge (R2)
    task automatic run_op(input logic d, input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
        logic [WORD_W-1:0] exp;
        string req;
        exp = ref_word(d, a, b, req);
        @(negedge clk);
        op_div = d; opnd_a = a; opnd_b = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, result, exp);
        check("R5", {7'd0, result[LOG_W]}, {7'd0, a[LOG_W] ^ b[LOG_W]});
        if (result[WORD_W-1:WORD_W-2] != 2'b01)
            check("R11", {3'd0, result[LOG_W-1:0]}, '0);
    endtask

    function automatic logic [WORD_W-1:0] rnd_word();
        logic [1:0] c;
        int p;
        p = int'($urandom % 8);
        c = (p == 0) ? 2'b00 : (p == 1) ? 2'b10 : (p == 2) ? 2'b11 : 2'b01;
        return {c, 1'($urandom), LOG_W'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", result, '0);                          // reset state
        rst_n = 1'b1;

        // R2: result does not move after only one edge
        @(negedge clk);
        op_div = 1'b0; opnd_a = mk(2'b01, 1'b0, 3); opnd_b = mk(2'b01, 1'b1, 4);
        @(posedge clk);
        @(negedge clk);
        check("R2", result, '0);
        @(posedge clk);
        @(negedge clk);
        check("R2", result, mk(2'b01, 1'b1, 7));

        // R1/R3/R4 directed exact results
        run_op(1'b0, mk(2'b01, 0, 8),  mk(2'b01, 0, 7));    // R3 boundary +15
        run_op(1'b0, mk(2'b01, 1, -8), mk(2'b01, 1, -8));   // R3 boundary -16
        run_op(1'b1, mk(2'b01, 0, 5),  mk(2'b01, 1, -10));  // R4 15
        run_op(1'b1, mk(2'b01, 1, -6), mk(2'b01, 0, 10));   // R4 -16
        // R6 / R7 just past the range
        run_op(1'b0, mk(2'b01, 0, 8),  mk(2'b01, 0, 8));    // R6
        run_op(1'b0, mk(2'b01, 0, LMAX), mk(2'b01, 1, LMAX)); // R6
        run_op(1'b0, mk(2'b01, 0, -9), mk(2'b01, 0, -8));   // R7
        run_op(1'b1, mk(2'b01, 0, LMAX), mk(2'b01, 0, LMIN)); // R6
        run_op(1'b1, mk(2'b01, 1, LMIN), mk(2'b01, 0, LMAX)); // R7
        // R8 / R9 / R10 directed exception pairs
        run_op(1'b0, mk(2'b11, 0, 3),  mk(2'b01, 1, 1));    // R8
        run_op(1'b1, mk(2'b00, 0, 0),  mk(2'b11, 0, 0));    // R8
        run_op(1'b0, mk(2'b00, 1, 0),  mk(2'b10, 0, 0));    // R9 NaN
        run_op(1'b0, mk(2'b01, 1, 5),  mk(2'b10, 1, 0));    // R9 inf
        run_op(1'b0, mk(2'b00, 0, 0),  mk(2'b01, 1, 9));    // R9 zero
        run_op(1'b1, mk(2'b10, 0, 0),  mk(2'b10, 1, 0));    // R10 inf/inf
        run_op(1'b1, mk(2'b00, 0, 0),  mk(2'b00, 0, 0));    // R10 0/0
        run_op(1'b1, mk(2'b01, 0, 2),  mk(2'b00, 1, 0));    // R10 x/0
        run_op(1'b1, mk(2'b01, 1, 2),  mk(2'b10, 0, 0));    // R10 x/inf
        run_op(1'b1, mk(2'b10, 1, 0),  mk(2'b01, 0, 2));    // R10 inf/x

        // Random mix, both modes
        for (int i = 0; i < 3000; i++) begin
            run_op(1'($urandom), rnd_word(), rnd_word());
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule